// File: doc/BRIEF.md
# One-Wire Addressing Sequencer

This block runs the addressing phase that comes before every device transaction on a one-wire bus. A start strobe makes it ask a slot master for a bus reset and presence check. If no device answers, it ends at once with an error and sends no command byte. If a device answers, it selects a target in one of two ways. When the caller reports a single device on the bus, it broadcasts one skip-address command byte. Otherwise it sends a match-address command byte followed by the eight bytes of the 64-bit device identifier.

The block does no slot timing of its own. It hands each step to a slot master as one request: either a reset with presence sample, or a byte write. Each request stays held until the slot master acknowledges it. The data phase after selection belongs to other logic. The identifier and the single-device flag are captured when a sequence starts, so the caller may change them while the sequence runs.

Top module: `onewire_select_seq`

## Requirements
- R1: The first request of every sequence is a reset operation (bus_rst_o = 1 while bus_req_o = 1).
- R2: If the reset request is acknowledged with bus_presence_i = 0, no byte request follows. done_o and error_o are both 1 in the cycle after that acknowledge.
- R3: With single_dev_i = 1 captured at start, exactly one byte request follows the reset, carrying 8'hCC.
- R4: With single_dev_i = 0 captured at start, nine byte requests follow the reset. The first carries 8'h55, then dev_id_i[7:0], dev_id_i[15:8] and so on up to dev_id_i[63:56].
- R5: One cycle after the acknowledge of the final byte request, done_o = 1 and error_o = 0.
- R6: start_i is ignored while a sequence runs. single_dev_i and dev_id_i are captured only when start_i is accepted, so later changes have no effect on the bytes sent.
- R7: While bus_req_o = 1 and no acknowledge arrives, bus_rst_o and bus_byte_o hold their values. After an acknowledge, bus_req_o staying high means a new request.
- R8: done_o is a one-cycle pulse. error_o holds its value until the next accepted start, which clears it.
- R9: With rst_ni low, bus_req_o, done_o and error_o are 0, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a sequence when the block is idle |
| single_dev_i | input | 1 | 1: one device known on the bus, use skip-address |
| dev_id_i | input | 64 | Identifier of the target device, byte 0 in bits 7:0 |
| bus_ack_i | input | 1 | Slot master finished the current request |
| bus_presence_i | input | 1 | Presence result, valid with bus_ack_i for a reset request |
| bus_req_o | output | 1 | Request to the slot master |
| bus_rst_o | output | 1 | 1: reset with presence sample, 0: byte write |
| bus_byte_o | output | 8 | Byte to write for a byte request |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| error_o | output | 1 | No presence seen in the last sequence |

## Verification
The assertions watch on every cycle that requests hold steady until acknowledged, that each sequence opens with a reset, and that a missing presence aborts at once. They also check that done is a single pulse, that a clean finish follows a byte acknowledge, that the error flag only moves at a start or a finish, and that the byte index stays in range. Only the bench scenarios can show that the bytes come out in the right order with the right values. They also show the total request count for each device-count and presence combination, and that inputs changed or starts pulsed mid-sequence leave the result unchanged. The sweep covers both selection modes, both presence outcomes and several acknowledge latencies, and adds a reset in the middle of a sequence.

// File: rtl/onewire_sel_pkg.sv
package onewire_sel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESET = 2'd1,
    ST_SEND  = 2'd2
  } sel_state_e;

  localparam logic [7:0] CMD_SKIP  = 8'hCC;
  localparam logic [7:0] CMD_MATCH = 8'h55;
endpackage

// File: rtl/sel_byte_cnt.sv
module sel_byte_cnt #(
  parameter int ID_BYTES = 8,
  parameter int CNT_W    = $clog2(ID_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             single_i,
  input  logic             inc_i,
  output logic             single_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ID_BYTES);

  logic single_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o    <= '0;
      single_q <= 1'b0;
    end else if (cap_i) begin
      idx_o    <= '0;
      single_q <= single_i;
    end else if (inc_i) begin
      idx_o <= idx_o + 1'b1;
    end
  end

  assign single_o = single_q;
  assign last_o   = single_q ? (idx_o == '0) : (idx_o == LAST_IDX);

  // R4
  idx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_o <= LAST_IDX);
endmodule

// File: rtl/sel_byte_mux.sv
module sel_byte_mux
  import onewire_sel_pkg::*;
#(
  parameter int ID_BYTES = 8,
  parameter int BYTE_W   = 8,
  parameter int CNT_W    = $clog2(ID_BYTES + 1),
  localparam int ID_W    = ID_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              single_i,
  input  logic [CNT_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [ID_W-1:0]   id_q;
  logic [BYTE_W-1:0] lane [ID_BYTES+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    id_q <= '0;
    else if (cap_i) id_q <= id_i;
  end

  assign lane[0] = single_i ? BYTE_W'(CMD_SKIP) : BYTE_W'(CMD_MATCH);

  // lowest-addressed identifier byte goes first
  for (genvar g = 0; g < ID_BYTES; g++) begin : g_lane
    assign lane[g+1] = id_q[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k <= ID_BYTES; k++) begin
      if (idx_i == CNT_W'(k)) byte_o = lane[k];
    end
  end
endmodule

// File: rtl/sel_ctrl.sv
module sel_ctrl
  import onewire_sel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  input  logic presence_i,
  input  logic last_i,
  output logic cap_o,
  output logic inc_o,
  output logic req_o,
  output logic rst_op_o,
  output logic done_o,
  output logic error_o
);
  sel_state_e state_q;

  assign cap_o = (state_q == ST_IDLE) && start_i;
  assign inc_o = (state_q == ST_SEND) && ack_i && !last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      req_o    <= 1'b0;
      rst_op_o <= 1'b0;
      done_o   <= 1'b0;
      error_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_RESET;
          req_o    <= 1'b1;
          rst_op_o <= 1'b1;
          error_o  <= 1'b0;
        end
        ST_RESET: if (ack_i) begin
          rst_op_o <= 1'b0;
          if (presence_i) begin
            state_q <= ST_SEND;
          end else begin
            // abort before any byte goes out
            state_q <= ST_IDLE;
            req_o   <= 1'b0;
            done_o  <= 1'b1;
            error_o <= 1'b1;
          end
        end
        ST_SEND: if (ack_i && last_i) begin
          state_q <= ST_IDLE;
          req_o   <= 1'b0;
          done_o  <= 1'b1;
          error_o <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  first_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> rst_op_o);

  // R2
  absent_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && rst_op_o && ack_i && !presence_i) |=> (!req_o && done_o && error_o));

  // R5
  success_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !error_o) |-> $past(req_o && !rst_op_o && ack_i));

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(rst_op_o)));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  error_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && !start_i) |=> $stable(error_o));
endmodule

// File: rtl/onewire_select_seq.sv
module onewire_select_seq #(
  parameter int ID_BYTES = 8,
  parameter int BYTE_W   = 8,
  localparam int ID_W    = ID_BYTES * BYTE_W,
  localparam int CNT_W   = $clog2(ID_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              single_dev_i,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic              bus_ack_i,
  input  logic              bus_presence_i,
  output logic              bus_req_o,
  output logic              bus_rst_o,
  output logic [BYTE_W-1:0] bus_byte_o,
  output logic              done_o,
  output logic              error_o
);
  logic             cap, inc, last, single_q;
  logic [CNT_W-1:0] idx;

  sel_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ack_i      (bus_ack_i),
    .presence_i (bus_presence_i),
    .last_i     (last),
    .cap_o      (cap),
    .inc_o      (inc),
    .req_o      (bus_req_o),
    .rst_op_o   (bus_rst_o),
    .done_o     (done_o),
    .error_o    (error_o)
  );

  sel_byte_cnt #(.ID_BYTES(ID_BYTES), .CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .single_i (single_dev_i),
    .inc_i    (inc),
    .single_o (single_q),
    .idx_o    (idx),
    .last_o   (last)
  );

  sel_byte_mux #(.ID_BYTES(ID_BYTES), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .id_i     (dev_id_i),
    .single_i (single_q),
    .idx_i    (idx),
    .byte_o   (bus_byte_o)
  );

  // R7
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> $stable(bus_byte_o));
endmodule

// File: tb/onewire_select_seq_test.sv
module onewire_select_seq_test;
  localparam int CLK_P    = 10;
  localparam int ID_BYTES = 8;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, single_dev_i = 1'b0;
  logic        bus_ack_i = 1'b0, bus_presence_i = 1'b0;
  logic [63:0] dev_id_i = '0;
  logic        bus_req_o, bus_rst_o, done_o, error_o;
  logic [7:0]  bus_byte_o;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  onewire_select_seq uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input bit single, input logic [63:0] id, input bit present,
                         input int lat, input bit disturb);
    int nreq = 0, guard = 0, exp_n;
    bit seen_done = 1'b0;
    logic [7:0] exp_b, hold_b;
    logic hold_op;
    exp_n = !present ? 1 : (single ? 2 : 2 + ID_BYTES);
    @(negedge clk_i); single_dev_i = single; dev_id_i = id; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(error_o === 1'b0, "R8 error cleared at start", error_o, 0);
    if (disturb) begin single_dev_i = ~single; dev_id_i = ~id; end
    while (!seen_done && guard < 400) begin
      guard++;
      if (done_o) seen_done = 1'b1;
      else if (bus_req_o) begin
        if (nreq == 0) chk(bus_rst_o === 1'b1, "R1 first request is reset", bus_rst_o, 1);
        else begin
          exp_b = (nreq == 1) ? (single ? 8'hCC : 8'h55) : id[8*(nreq-2) +: 8];
          chk(bus_rst_o === 1'b0 && bus_byte_o === exp_b,
              single ? "R3 skip byte" : (disturb ? "R6 R4 match bytes" : "R4 match bytes"),
              bus_byte_o, exp_b);
        end
        nreq++;
        hold_b = bus_byte_o; hold_op = bus_rst_o;
        for (int k = 0; k < lat; k++) begin
          if (disturb) start_i = 1'b1;
          @(negedge clk_i); start_i = 1'b0;
          chk(bus_req_o === 1'b1 && bus_byte_o === hold_b && bus_rst_o === hold_op,
              "R7 request held", {bus_req_o, bus_rst_o, bus_byte_o}, {1'b1, hold_op, hold_b});
        end
        bus_presence_i = present; bus_ack_i = 1'b1;
        @(negedge clk_i); bus_ack_i = 1'b0; bus_presence_i = 1'b0;
      end else @(negedge clk_i);
    end
    chk(seen_done, "R5 done reached", seen_done, 1);
    chk(nreq == exp_n, present ? (single ? "R3 request count" : "R4 request count")
                               : "R2 no byte after missing presence", nreq, exp_n);
    chk(error_o === !present, present ? "R5 no error" : "R2 error flagged", error_o, !present);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R8 done one cycle", done_o, 0);
    chk(error_o === !present, "R8 error held", error_o, !present);
    chk(bus_req_o === 1'b0, "R6 no restart from ignored start", bus_req_o, 0);
    single_dev_i = 1'b0; dev_id_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lats[3] = '{0, 1, 3};
    int n = 0;
    repeat (3) @(negedge clk_i);
    chk(bus_req_o === 0 && done_o === 0 && error_o === 0, "R9 reset state",
        {bus_req_o, done_o, error_o}, 0);
    rst_ni = 1'b1;
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 2; p++)
        for (int l = 0; l < 3; l++) begin
          n++;
          run_seq(s[0], 64'h0123_4567_89AB_CDEF ^ (64'(n) * 64'h9E37_79B9_7F4A_7C15),
                  p[0], lats[l], lats[l] > 0);
        end
    // reset in the middle of an addressed sequence
    @(negedge clk_i); dev_id_i = 64'hFEDC_BA98_7654_3210; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    bus_ack_i = 1'b1; bus_presence_i = 1'b1;
    @(negedge clk_i); bus_ack_i = 1'b0; bus_presence_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    chk(bus_req_o === 0 && done_o === 0 && error_o === 0, "R9 reset mid-sequence",
        {bus_req_o, done_o, error_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(bus_req_o === 1'b0, "R9 idle after reset", bus_req_o, 0);
    run_seq(1'b0, 64'h1122_3344_5566_7788, 1'b1, 2, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule